// File: doc/BRIEF.md
# RMII Receive Dibit-to-Byte Deserializer

This block sits between the two-bit receive pins of a reduced media-independent PHY link and the byte-wide receive path of an Ethernet MAC. Everything runs on the single 50 MHz reference clock. The carrier-sense/data-valid input may change at any time relative to that clock, so it passes through a two-flop synchronizer. The receive data and error inputs are delayed by the same two cycles so that they stay aligned with it. The synchronized level is also driven out as the carrier indication.

While synchronized data-valid is high, the block accepts dibits and packs each four of them into one byte, lowest bits first. At 100 Mbps it accepts a dibit on every clock. At 10 Mbps it accepts one dibit out of every ten clocks, and the sampling phase restarts each time data-valid rises. Each completed byte is held back by one byte. This lets the block mark the end of a frame on the last complete byte once data-valid falls. Each byte leaves as a one-cycle pulse that carries start-of-frame, end-of-frame and error flags. The block does no preamble handling, CRC checking, filtering or buffering.

Top module: `rmii_rx_deser`

## Requirements
- R1: Each output byte is assembled from four accepted dibits: the first accepted dibit forms bits 1:0, the second bits 3:2, the third bits 5:4 and the fourth bits 7:6. Within each dibit, input bit 0 is the less significant bit.
- R2: While synchronized data-valid is low, the data and error inputs are ignored. No byte is emitted except the end-of-frame byte released on the falling edge.
- R3: `carrier` equals the data-valid input as sampled two clock edges earlier, and it is low after reset.
- R4: With `rate_10m` low, one dibit is accepted on every clock while synchronized data-valid is high.
- R5: With `rate_10m` high, a dibit is accepted on the first clock on which synchronized data-valid is high, and then on every tenth clock after it. Data and error values on the other clocks are ignored.
- R6: `out_sof` is set, together with `out_valid`, on exactly the first byte of each frame.
- R7: `out_eof` is set on the last complete byte of a frame. That byte is emitted two clocks after the data-valid input falls.
- R8: If 1 to 3 dibits are left over when a frame ends, they are discarded and `out_err` is set on the end-of-frame byte. A frame with no complete byte emits nothing.
- R9: `out_err` is set on a byte if `rx_er` was high on any accepted dibit of that byte.
- R10: Each byte is presented for a single clock, and the frame's bytes come out in arrival order.
- R11: During reset `out_valid`, `out_sof`, `out_eof`, `out_err` and `carrier` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 50 MHz reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 2 | Receive dibit, bit 0 least significant |
| crs_dv | input | 1 | Carrier sense / receive data valid, asynchronous |
| rx_er | input | 1 | Receive error from the PHY |
| rate_10m | input | 1 | 1 selects 10 Mbps decimated sampling, 0 selects 100 Mbps |
| out_data | output | 8 | Assembled byte |
| out_valid | output | 1 | One-cycle byte strobe |
| out_sof | output | 1 | First byte of a frame |
| out_eof | output | 1 | Last complete byte of a frame |
| out_err | output | 1 | Byte saw a receive error or a truncated tail |
| carrier | output | 1 | Synchronized carrier indication |

## Verification
The assertions assume that `rate_10m` is constant within a frame. They also assume that data-valid stays low for at least one synchronized cycle between frames, so that a new frame is always preceded by a visible fall. The bench changes the rate only during the idle gap and leaves data-valid low for eight clocks between frames. The bench drives random values on the data and error inputs during gaps and on the clocks that decimation skips, so that those assumptions are the only ones in force.

// File: rtl/rmii_rx_pkg.sv
package rmii_rx_pkg;
    localparam int DIBIT_W      = 2;
    localparam int BYTE_W       = 8;
    localparam int DIBITS_PER_B = BYTE_W / DIBIT_W;
    localparam int SLOT_W       = $clog2(DIBITS_PER_B);

    typedef logic [DIBIT_W-1:0] dibit_t;
    typedef logic [BYTE_W-1:0]  byte_t;
    typedef logic [SLOT_W-1:0]  slot_t;

    typedef struct packed {
        byte_t data;
        logic  err;
        logic  first;
    } held_t;
endpackage

// File: rtl/rmii_rx_sync.sv
module rmii_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         crs_dv,
    input  rmii_rx_pkg::dibit_t          rxd,
    input  logic                         rx_er,
    output logic                         dv_s,
    output rmii_rx_pkg::dibit_t          dibit_s,
    output logic                         er_s
);
    import rmii_rx_pkg::*;

    typedef struct packed {
        logic   [STAGES-1:0] crs;
        dibit_t [STAGES-1:0] dat;
        logic   [STAGES-1:0] er;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.crs = {st_q.crs[STAGES-2:0], crs_dv};
        st_d.dat = {st_q.dat[STAGES-2:0], rxd};
        st_d.er  = {st_q.er[STAGES-2:0], rx_er};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dv_s    = st_q.crs[STAGES-1];
    assign dibit_s = st_q.dat[STAGES-1];
    assign er_s    = st_q.er[STAGES-1];
endmodule

// File: rtl/rmii_rx_strobe.sv
module rmii_rx_strobe #(
    parameter int DECIM = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rate_10m,
    input  logic dv_s,
    output logic strobe
);
    localparam int CNT_W = $clog2(DECIM);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             dv_prev;
    } dec_t;

    dec_t dc_d, dc_q;
    logic [CNT_W-1:0] phase;
    logic             rise;

    always_comb begin
        dc_d = dc_q;
        rise = dv_s && !dc_q.dv_prev;
        phase = rise ? '0 : dc_q.cnt;
        dc_d.dv_prev = dv_s;
        if (!dv_s)
            dc_d.cnt = '0;
        else if (phase == CNT_W'(DECIM - 1))
            dc_d.cnt = '0;
        else
            dc_d.cnt = phase + 1'b1;
        strobe = dv_s && (!rate_10m || phase == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dc_q <= '0;
        else        dc_q <= dc_d;
    end

    // R5: decimated accepts are never adjacent
    a_r5_spaced: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_10m && strobe) |=> !strobe);
endmodule

// File: rtl/rmii_rx_pack.sv
module rmii_rx_pack (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 dv_s,
    input  logic                 strobe,
    input  rmii_rx_pkg::dibit_t  dibit,
    input  logic                 er,
    output rmii_rx_pkg::byte_t   out_data,
    output logic                 out_valid,
    output logic                 out_sof,
    output logic                 out_eof,
    output logic                 out_err
);
    import rmii_rx_pkg::*;

    typedef struct packed {
        byte_t acc;
        slot_t slot;
        logic  err_acc;
        held_t held;
        logic  held_vld;
        logic  first_pend;
        logic  dv_prev;
        byte_t o_data;
        logic  o_valid;
        logic  o_sof;
        logic  o_eof;
        logic  o_err;
    } pk_t;

    pk_t pk_d, pk_q;
    logic  rise, fall;
    slot_t slot_b;
    logic  err_b, first_b;
    byte_t acc_n;
    logic  err_n;

    always_comb begin
        pk_d = pk_q;
        pk_d.o_valid = 1'b0;
        pk_d.o_sof   = 1'b0;
        pk_d.o_eof   = 1'b0;
        pk_d.o_err   = 1'b0;
        pk_d.dv_prev = dv_s;
        rise    = dv_s && !pk_q.dv_prev;
        fall    = !dv_s && pk_q.dv_prev;
        slot_b  = rise ? '0 : pk_q.slot;
        err_b   = rise ? 1'b0 : pk_q.err_acc;
        first_b = rise ? 1'b1 : pk_q.first_pend;
        acc_n   = {dibit, pk_q.acc[BYTE_W-1:DIBIT_W]};
        err_n   = err_b | er;
        if (rise) begin
            pk_d.slot       = '0;
            pk_d.err_acc    = 1'b0;
            pk_d.first_pend = 1'b1;
            pk_d.held_vld   = 1'b0;
        end
        if (strobe) begin
            pk_d.acc = acc_n;
            if (slot_b == slot_t'(DIBITS_PER_B - 1)) begin
                if (pk_q.held_vld && !rise) begin
                    pk_d.o_valid = 1'b1;
                    pk_d.o_data  = pk_q.held.data;
                    pk_d.o_sof   = pk_q.held.first;
                    pk_d.o_err   = pk_q.held.err;
                end
                pk_d.held.data  = acc_n;
                pk_d.held.err   = err_n;
                pk_d.held.first = first_b;
                pk_d.held_vld   = 1'b1;
                pk_d.first_pend = 1'b0;
                pk_d.slot       = '0;
                pk_d.err_acc    = 1'b0;
            end else begin
                pk_d.slot       = slot_b + 1'b1;
                pk_d.err_acc    = err_n;
                pk_d.first_pend = first_b;
            end
        end
        if (fall) begin
            if (pk_q.held_vld) begin
                pk_d.o_valid = 1'b1;
                pk_d.o_data  = pk_q.held.data;
                pk_d.o_sof   = pk_q.held.first;
                pk_d.o_eof   = 1'b1;
                pk_d.o_err   = pk_q.held.err | (pk_q.slot != '0);
            end
            pk_d.held_vld = 1'b0;
            pk_d.slot     = '0;
            pk_d.err_acc  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pk_q <= '0;
        else        pk_q <= pk_d;
    end

    assign out_data  = pk_q.o_data;
    assign out_valid = pk_q.o_valid;
    assign out_sof   = pk_q.o_sof;
    assign out_eof   = pk_q.o_eof;
    assign out_err   = pk_q.o_err;

    // R2: with data-valid low on both sides of an edge, nothing is emitted
    a_r2_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!dv_s && !pk_q.dv_prev) |=> !out_valid);
    // R6: start marker rides on a valid byte and never repeats next cycle
    a_r6_sof_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> out_valid);
    a_r6_sof_single: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |=> !out_sof);
    // R7: end marker rides on a valid byte
    a_r7_eof_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_eof |-> out_valid);
endmodule

// File: rtl/rmii_rx_deser.sv
module rmii_rx_deser #(
    parameter int SYNC_STAGES = 2,
    parameter int DECIM       = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] rxd,
    input  logic       crs_dv,
    input  logic       rx_er,
    input  logic       rate_10m,
    output logic [7:0] out_data,
    output logic       out_valid,
    output logic       out_sof,
    output logic       out_eof,
    output logic       out_err,
    output logic       carrier
);
    import rmii_rx_pkg::*;

    logic   dv_s, er_s, strobe;
    dibit_t dibit_s;

    rmii_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .crs_dv(crs_dv), .rxd(rxd), .rx_er(rx_er),
        .dv_s(dv_s), .dibit_s(dibit_s), .er_s(er_s)
    );

    rmii_rx_strobe #(.DECIM(DECIM)) u_strobe (
        .clk(clk), .rst_n(rst_n), .rate_10m(rate_10m), .dv_s(dv_s),
        .strobe(strobe)
    );

    rmii_rx_pack u_pack (
        .clk(clk), .rst_n(rst_n), .dv_s(dv_s), .strobe(strobe),
        .dibit(dibit_s), .er(er_s), .out_data(out_data),
        .out_valid(out_valid), .out_sof(out_sof), .out_eof(out_eof),
        .out_err(out_err)
    );

    assign carrier = dv_s;

    // R3: a rising carrier reflects the input two edges back
    a_r3_carrier_lag: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(carrier) |-> $past(crs_dv, 2));
endmodule

// File: tb/rmii_rx_deser_tb.sv
`timescale 1ns/1ps
module rmii_rx_deser_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] rxd = '0;
    logic       crs_dv = 1'b0;
    logic       rx_er = 1'b0;
    logic       rate_10m = 1'b0;
    logic [7:0] out_data;
    logic       out_valid, out_sof, out_eof, out_err, carrier;

    int checks = 0;
    int fails  = 0;
    logic [10:0] got[$];
    logic h0 = 1'b0, h1 = 1'b0;
    bit   mon_on = 1'b0;

    always #2 clk = ~clk;

    rmii_rx_deser u_dut (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .crs_dv(crs_dv), .rx_er(rx_er),
        .rate_10m(rate_10m), .out_data(out_data), .out_valid(out_valid),
        .out_sof(out_sof), .out_eof(out_eof), .out_err(out_err),
        .carrier(carrier)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // input history for R3 (carrier lags two edges)
    always @(posedge clk) begin
        h1 <= h0;
        h0 <= crs_dv;
    end

    always @(negedge clk) begin
        if (mon_on) begin
            if (carrier !== h1) chk(1'b0, "R3 carrier", carrier, h1);
            if (out_valid) got.push_back({out_err, out_eof, out_sof, out_data});
        end
    end

    function automatic logic [7:0] pat(input int seed, input int i);
        return 8'((seed * 13 + i * 37 + 5) & 255);
    endfunction

    task automatic frame(input int nb, input int extra, input bit slow,
                         input int errd, input int seed);
        int total = nb * 4 + extra;
        int reps  = slow ? 10 : 1;
        got.delete();
        rate_10m = slow;
        for (int j = 0; j < total; j++) begin
            for (int r = 0; r < reps; r++) begin
                @(posedge clk); #1;
                crs_dv = 1'b1;
                if (r == 0) begin
                    rxd   = (j < nb * 4) ? 2'((pat(seed, j / 4) >> (2 * (j % 4))) & 3)
                                         : 2'($urandom);
                    rx_er = (j == errd);
                end else begin
                    rxd   = 2'($urandom);
                    rx_er = 1'($urandom);
                end
            end
        end
        for (int g = 0; g < 8; g++) begin
            @(posedge clk); #1;
            crs_dv = 1'b0;
            rxd    = 2'($urandom);
            rx_er  = 1'($urandom);
        end
        // R2 R4 R5 R8: number of bytes seen equals complete bytes sent
        chk(got.size() == nb, slow ? "R5 count" : "R4 count", got.size(), nb);
        for (int i = 0; i < nb && i < got.size(); i++) begin
            logic ee = (errd >= 0 && errd / 4 == i) || (i == nb - 1 && extra > 0);
            chk(got[i][7:0] == pat(seed, i), "R1 byte order", got[i][7:0], pat(seed, i));
            chk(got[i][8] == (i == 0), "R6 sof", got[i][8], i == 0);
            chk(got[i][9] == (i == nb - 1), "R7 eof", got[i][9], i == nb - 1);
            chk(got[i][10] == ee, (i == nb - 1 && extra > 0) ? "R8 tail err" : "R9 err",
                got[i][10], ee);
        end
    endtask

    initial begin
        #200000;
        chk(1'b0, "watchdog", 0, 1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        crs_dv = 1'b1;
        repeat (2) @(negedge clk);
        // R11 reset state
        chk({out_valid, out_sof, out_eof, out_err, carrier} == 5'b0, "R11 reset",
            {out_valid, out_sof, out_eof, out_err, carrier}, 0);
        crs_dv = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        mon_on = 1'b1;
        // R10 R2: single-cycle bytes in order, idle ignored; sweep
        for (int s = 0; s < 2; s++)
            for (int nb = 0; nb < 5; nb++)
                for (int ex = 0; ex < 4; ex++) begin
                    int tot = nb * 4 + ex;
                    frame(nb, ex, s[0], -1, nb * 7 + ex);
                    if (tot > 0) frame(nb, ex, s[0], (nb * 3 + ex) % tot, nb + ex * 11);
                end
        frame(6, 0, 1'b0, 23, 99);
        frame(3, 1, 1'b1, 0, 42);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule